// File: doc/BRIEF.md
# Fractional reference clock divider

The block produces one reference clock from one of three parent clocks. The output frequency is the parent frequency divided by twice an integer divisor plus a fractional trim in steps of 1/512. The parent clocks are free-running levels that the block samples on its own bus clock. A fractional accumulator spreads the trim by stretching individual half-periods by one parent cycle.

Software programs the source select, the integer divisor and the trim through a small word-addressed register bus. Each register also has a write-one-to-clear alias and a write-one-to-set alias. New divisor and trim values stay inactive until software raises a switch request. The hardware applies them at a half-period boundary of the output, or at once while the output is stopped, and then clears the request by itself. An ACTIVE status bit reports that the output is running from a valid source.

Top module: `refclk_frac_div`

## Requirements
- R1: After reset the control word (index 0) and the trim word (index 4) both read 0 and `ref_clk_o` is low.
- R2: Control word layout: select in bits 3:0, ACTIVE (read-only) in bit 8, switch request in bit 9, output enable in bit 10+2=12, ON in bit 15, divisor in bits 30:16. Trim word: trim in bits 31:23. Other bits read 0, and a write to ACTIVE has no effect.
- R3: Word index 1 clears and index 2 sets the written-one bits of the control word; indices 5 and 6 do the same for the trim word. Bits written as zero keep their value.
- R4: With divisor D > 0 and trim 0, each output period lasts exactly 2·D parent cycles.
- R5: With divisor D > 0 and trim T, any 256 consecutive output periods (512 half-periods) last exactly 512·D + T parent cycles.
- R6: With an active divisor of 0 the output follows the parent: one output period per parent cycle.
- R7: A written divisor or trim has no effect on the output until a switch request is raised. The active values change only while a request is pending, and the request bit reads 0 again once they are applied.
- R8: Select code 0 chooses `sys_clk_i`, 7 chooses `pll_clk_i` and 8 chooses `ext_clk_i`. Any other code produces no output edges and ACTIVE reads 0.
- R9: ACTIVE reads 1 while ON and output enable are both set with a valid source. It reads 0 by the second cycle after ON is cleared. The output stays low while ON or output enable is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Word index: 0 control, 1 control clear, 2 control set, 4 trim, 5 trim clear, 6 trim set |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| sys_clk_i | input | 1 | System clock parent (select 0) |
| pll_clk_i | input | 1 | PLL parent (select 7) |
| ext_clk_i | input | 1 | External reference parent (select 8) |
| ref_clk_o | output | 1 | Divided reference clock |

## Verification
On every cycle the assertions check the following: the active divisor and trim move only while a switch request is pending; a pending request clears itself while the output is stopped; ACTIVE is never set for an unlisted select code; ACTIVE falls after ON drops; and the clear alias really clears ON. The exact output periods for integer, fractional and pass-through division appear only in the bench's scenarios, which count parent edges over whole runs of output periods. The same holds for the absence of any effect before a switch and for the silence under an invalid select.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam logic [3:0] SRC_SYS = 4'd0;
  localparam logic [3:0] SRC_PLL = 4'd7;
  localparam logic [3:0] SRC_EXT = 4'd8;
  localparam int NSRC     = 3;
  localparam int SEL_LSB  = 0;
  localparam int ACT_BIT  = 8;
  localparam int SW_BIT   = 9;
  localparam int OE_BIT   = 12;
  localparam int ON_BIT   = 15;
  localparam int DIV_LSB  = 16;
  localparam int TRIM_LSB = 23;

  typedef enum logic [1:0] {OP_WR = 2'd0, OP_CLR = 2'd1, OP_SET = 2'd2, OP_NONE = 2'd3} op_e;

  function automatic logic [31:0] apply_op(op_e op, logic [31:0] cur, logic [31:0] wd);
    case (op)
      OP_WR:   return wd;
      OP_CLR:  return cur & ~wd;
      OP_SET:  return cur | wd;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/refdiv_regs.sv
module refdiv_regs import refdiv_pkg::*; #(
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              active_i,
  input  logic              sw_done_i,
  output logic [31:0]       rdata_o,
  output logic [3:0]        sel_o,
  output logic              on_o,
  output logic              oe_o,
  output logic              divsw_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [TRIM_W-1:0] trim_o
);
  logic [31:0] ctrl_img, trim_img, ctrl_nxt, trim_nxt;
  op_e         op;
  logic        ctrl_we, trim_we, sw_set;
  logic        unused_bits;

  assign op      = op_e'(addr_i[1:0]);
  assign ctrl_we = we_i && !addr_i[2] && (op != OP_NONE);
  assign trim_we = we_i &&  addr_i[2] && (op != OP_NONE);
  assign sw_set  = ctrl_we && (op != OP_CLR) && wdata_i[SW_BIT];

  always_comb begin
    ctrl_img = '0;
    ctrl_img[SEL_LSB +: 4]     = sel_o;
    ctrl_img[ACT_BIT]          = active_i;
    ctrl_img[SW_BIT]           = divsw_o;
    ctrl_img[OE_BIT]           = oe_o;
    ctrl_img[ON_BIT]           = on_o;
    ctrl_img[DIV_LSB +: DIV_W] = div_o;
    trim_img = '0;
    trim_img[TRIM_LSB +: TRIM_W] = trim_o;
  end

  assign ctrl_nxt = apply_op(op, ctrl_img, wdata_i);
  assign trim_nxt = apply_op(op, trim_img, wdata_i);
  assign rdata_o  = addr_i[2] ? trim_img : ctrl_img;
  assign unused_bits = ^{ctrl_nxt, trim_nxt};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o   <= '0;
      on_o    <= 1'b0;
      oe_o    <= 1'b0;
      divsw_o <= 1'b0;
      div_o   <= '0;
      trim_o  <= '0;
    end else begin
      if (ctrl_we) begin
        sel_o <= ctrl_nxt[SEL_LSB +: 4];
        oe_o  <= ctrl_nxt[OE_BIT];
        on_o  <= ctrl_nxt[ON_BIT];
        div_o <= ctrl_nxt[DIV_LSB +: DIV_W];
      end
      if (trim_we) trim_o <= trim_nxt[TRIM_LSB +: TRIM_W];
      if (sw_set)         divsw_o <= 1'b1;
      else if (sw_done_i) divsw_o <= 1'b0;
    end
  end
endmodule

// File: rtl/refdiv_src.sv
module refdiv_src import refdiv_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [3:0]      sel_i,
  output logic            lvl_o,
  output logic            tick_o,
  output logic            valid_o
);
  logic [NSRC-1:0] s1, s2;
  logic            pick;

  for (genvar i = 0; i < NSRC; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1[i] <= 1'b0;
        s2[i] <= 1'b0;
      end else begin
        s1[i] <= src_i[i];
        s2[i] <= s1[i];
      end
    end
  end

  always_comb begin
    pick    = 1'b0;
    valid_o = 1'b1;
    case (sel_i)
      SRC_SYS: pick = s2[0];
      SRC_PLL: pick = s2[1];
      SRC_EXT: pick = s2[2];
      default: valid_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_o <= 1'b0;
    else         lvl_o <= pick;
  end

  assign tick_o = pick && !lvl_o;
endmodule

// File: rtl/refdiv_core.sv
module refdiv_core #(
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              lvl_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              sw_req_i,
  output logic              clk_o,
  output logic              sw_done_o,
  output logic [DIV_W-1:0]  act_div_o,
  output logic [TRIM_W-1:0] act_trim_o
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0]     cnt, len;
  logic [TRIM_W-1:0] acc;
  logic [TRIM_W:0]   sum;
  logic              stretch, passthru, edge_hit, bnd;

  assign passthru  = (act_div_o == '0);
  assign len       = {1'b0, act_div_o} + CW'(stretch);
  assign edge_hit  = tick_i && (cnt + CW'(1) == len);
  assign bnd       = passthru ? tick_i : edge_hit;
  assign sum       = {1'b0, acc} + {1'b0, act_trim_o};
  assign sw_done_o = sw_req_i && (!run_i || bnd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt        <= '0;
      acc        <= '0;
      stretch    <= 1'b0;
      clk_o      <= 1'b0;
      act_div_o  <= '0;
      act_trim_o <= '0;
    end else begin
      if (sw_done_o) begin
        act_div_o  <= div_i;
        act_trim_o <= trim_i;
      end
      if (!run_i) begin
        cnt     <= '0;
        acc     <= '0;
        stretch <= 1'b0;
        clk_o   <= 1'b0;
      end else if (passthru) begin
        cnt   <= '0;
        clk_o <= lvl_i;
      end else if (tick_i) begin
        if (edge_hit) begin
          cnt            <= '0;
          clk_o          <= ~clk_o;
          {stretch, acc} <= sum;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/refclk_frac_div.sv
module refclk_frac_div import refdiv_pkg::*; #(
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 9
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [2:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        sys_clk_i,
  input  logic        pll_clk_i,
  input  logic        ext_clk_i,
  output logic        ref_clk_o
);
  logic [3:0]        sel_q;
  logic              on_q, oe_q, divsw_q, active_q, sw_done;
  logic [DIV_W-1:0]  div_q, act_div;
  logic [TRIM_W-1:0] trim_q, act_trim;
  logic              lvl, tick, src_ok, div_clk, ref_q;

  refdiv_regs #(.DIV_W(DIV_W), .TRIM_W(TRIM_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .active_i(active_q), .sw_done_i(sw_done),
    .rdata_o(bus_rdata_o), .sel_o(sel_q), .on_o(on_q), .oe_o(oe_q),
    .divsw_o(divsw_q), .div_o(div_q), .trim_o(trim_q)
  );

  refdiv_src u_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i({ext_clk_i, pll_clk_i, sys_clk_i}),
    .sel_i(sel_q), .lvl_o(lvl), .tick_o(tick), .valid_o(src_ok)
  );

  refdiv_core #(.DIV_W(DIV_W), .TRIM_W(TRIM_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(on_q), .tick_i(tick), .lvl_i(lvl),
    .div_i(div_q), .trim_i(trim_q), .sw_req_i(divsw_q), .clk_o(div_clk),
    .sw_done_o(sw_done), .act_div_o(act_div), .act_trim_o(act_trim)
  );

  // registered gate keeps the output free of combinational glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ref_q    <= 1'b0;
    end else begin
      active_q <= on_q && oe_q && src_ok;
      ref_q    <= on_q && oe_q && div_clk;
    end
  end

  assign ref_clk_o = ref_q;
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker #(
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [2:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic              on_i,
  input logic [3:0]        sel_i,
  input logic              divsw_i,
  input logic              active_i,
  input logic [DIV_W-1:0]  act_div_i,
  input logic [TRIM_W-1:0] act_trim_i
);
  logic sw_write;
  assign sw_write = we_i && !addr_i[2] && (addr_i[1:0] != 2'd1) && (addr_i[1:0] != 2'd3) && wdata_i[9];

  p_act_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !divsw_i |=> ($stable(act_div_i) && $stable(act_trim_i)));

  p_sw_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divsw_i && !on_i && !sw_write) |=> !divsw_i);

  p_active_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (sel_i == 4'd0 || sel_i == 4'd7 || sel_i == 4'd8));

  p_active_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_i |=> !active_i);

  p_clr_on_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd1 && wdata_i[15]) |=> !on_i);
endmodule

bind refclk_frac_div refdiv_checker #(.DIV_W(DIV_W), .TRIM_W(TRIM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
  .wdata_i(bus_wdata_i), .on_i(on_q), .sel_i(sel_q), .divsw_i(divsw_q),
  .active_i(active_q), .act_div_i(act_div), .act_trim_i(act_trim)
);

// File: tb/tb_refclk_frac_div.sv
`timescale 1ns/1ps
module tb_refclk_frac_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_c = 1'b0, pll_c = 1'b0, ext_c = 1'b0;
  logic        ref_o;

  int checks = 0, errors = 0;
  int sys_n = 0, pll_n = 0, ext_n = 0;
  int sys_r = 0, pll_r = 0, ext_r = 0, ref_r = 0;
  logic ref_prev = 1'b0;

  refclk_frac_div dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sys_clk_i(sys_c),
    .pll_clk_i(pll_c), .ext_clk_i(ext_c), .ref_clk_o(ref_o)
  );

  always #4 clk = ~clk;

  // parent periods: sys 4, pll 6, ext 10 bus cycles; edge counters
  always @(negedge clk) begin
    sys_c = (sys_n % 4) < 2;  if (sys_n % 4 == 0) sys_r++;  sys_n++;
    pll_c = (pll_n % 6) < 3;  if (pll_n % 6 == 0) pll_r++;  pll_n++;
    ext_c = (ext_n % 10) < 5; if (ext_n % 10 == 0) ext_r++; ext_n++;
    if (ref_o && !ref_prev) ref_r++;
    ref_prev = ref_o;
  end

  function automatic int par_cnt(int sel);
    if (sel == 7) return pll_r;
    if (sel == 8) return ext_r;
    return sys_r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); #1;
    we = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); #1;
    addr = 3'(a); #1;
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_sw(output int ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      rd(0, v);
      if (!v[9]) begin ok = 1; break; end
    end
  endtask

  // cycles of the selected parent over n output periods
  task automatic meas(int sel, int n, output int cyc);
    int r0, p0;
    r0 = ref_r;
    while (ref_r == r0) begin @(negedge clk); #1; end
    p0 = par_cnt(sel); r0 = ref_r;
    while (ref_r < r0 + n) begin @(negedge clk); #1; end
    cyc = par_cnt(sel) - p0;
  endtask

  function automatic logic [31:0] ctrl_word(int sel, int div, bit on, bit oe);
    logic [31:0] w;
    w = '0;
    w[3:0] = 4'(sel); w[30:16] = 15'(div); w[15] = on; w[12] = oe;
    return w;
  endfunction

  task automatic cfg(int sel, int div, int trim);
    logic [31:0] v;
    int ok;
    wr(1, 32'h0000_9000);
    idle(3);
    wr(4, {9'(trim), 23'h0});
    wr(0, ctrl_word(sel, div, 0, 0));
    wr(2, 32'h0000_0200);
    wait_sw(ok);
    chk("R7 request self-clear", ok, 1);
    wr(2, 32'h0000_9000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc, r0, d, t, s, ok;
    process::self().srandom(32'd5117);
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(0, v); chk("R1 ctrl reset", int'(v), 0);
    rd(4, v); chk("R1 trim reset", int'(v), 0);
    chk("R1 output low", int'(ref_o), 0);

    // R2 layout, ACTIVE read-only, reserved bits read 0
    wr(0, 32'h8003_1D45);
    rd(0, v); chk("R2 ctrl layout", int'(v), 32'h0003_1005);
    wr(4, 32'hFFFF_FFFF);
    rd(4, v); chk("R2 trim layout", int'(v), 32'hFF80_0000);

    // R3 aliases
    wr(5, 32'h4000_0000);
    rd(4, v); chk("R3 trim clear alias", int'(v), 32'hBF80_0000);
    wr(6, 32'h4000_0000);
    rd(4, v); chk("R3 trim set alias", int'(v), 32'hFF80_0000);
    wr(2, 32'h0000_8000);
    rd(0, v); chk("R3 ctrl set alias", int'(v & 32'hFFFF_FEFF), 32'h0003_9005);
    wr(1, 32'h0000_1000);
    rd(0, v); chk("R3 ctrl clear alias", int'(v & 32'hFFFF_FEFF), 32'h0003_8005);

    // R7: divisor 3 written but never switched; output still pass-through (R6)
    wr(1, 32'hFFFF_FFFF);
    wr(4, 32'h0);
    wr(0, ctrl_word(0, 3, 1, 1));
    meas(0, 8, cyc); chk("R7 no effect before switch", cyc, 8);
    rd(0, v); chk("R9 active while running", int'(v[8]), 1);

    // R4 integer division after switch
    cfg(0, 3, 0);
    meas(0, 16, cyc); chk("R4 div3 period", cyc, 96);
    cfg(7, 5, 0);
    meas(7, 10, cyc); chk("R4 div5 pll period", cyc, 100);

    // R5 fractional corners
    cfg(0, 3, 511);
    meas(0, 256, cyc); chk("R5 trim max", cyc, 512 * 3 + 511);
    cfg(0, 1, 1);
    meas(0, 256, cyc); chk("R5 trim min", cyc, 512 + 1);

    // R5 random divisor, trim, source
    for (int i = 0; i < 4; i++) begin
      d = 1 + int'($urandom % 4);
      t = int'($urandom % 512);
      s = ($urandom % 2) ? 7 : 0;
      cfg(s, d, t);
      meas(s, 256, cyc); chk("R5 random fractional", cyc, 512 * d + t);
    end

    // R6 pass-through after switching divisor 0
    cfg(0, 0, 0);
    meas(0, 10, cyc); chk("R6 pass-through", cyc, 10);

    // R8 external source and invalid code
    cfg(8, 2, 0);
    meas(8, 8, cyc); chk("R8 ext source", cyc, 32);
    rd(0, v); chk("R8 active ext", int'(v[8]), 1);
    cfg(3, 2, 0);
    idle(4);
    rd(0, v); chk("R8 invalid active", int'(v[8]), 0);
    r0 = ref_r; idle(200);
    chk("R8 invalid no edges", ref_r - r0, 0);

    // R9 stop via clear alias, output enable gating
    cfg(0, 1, 0);
    idle(8);
    rd(0, v); chk("R9 active on", int'(v[8]), 1);
    wr(1, 32'h0000_8000);
    idle(1);
    rd(0, v); chk("R9 active falls", int'(v[8]), 0);
    r0 = ref_r; idle(100);
    chk("R9 output silent when off", ref_r - r0, 0);
    wr(2, 32'h0000_8000);
    wr(1, 32'h0000_1000);
    idle(4);
    rd(0, v); chk("R9 active with oe clear", int'(v[8]), 0);
    r0 = ref_r; idle(100);
    chk("R9 output silent oe clear", ref_r - r0, 0);
    wr(2, 32'h0000_1000);
    wait_sw(ok);
    meas(0, 8, cyc); chk("R9 restart period", cyc, 16);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule